// File: doc/BRIEF.md
# Serial Port Status Flag Unit

This unit keeps the error and completion flags of an asynchronous serial port that can tag each frame with a multiprocessor bit. The receive shift engine sends it a strobe for each finished frame, with that frame's parity outcome and its multiprocessor bit. The transmit shift engine reports when the final bit of a character leaves the line. The unit then updates a parity-error flag, a transmit-end flag, a captured receive multiprocessor bit and a software-written transmit multiprocessor bit. It tells the receive path when to load the received byte and when to mark the data register full, and it halts reception after a parity error.

Software sees all the flags in one status word. Flags that software can clear use an armed read-then-write rule: a write of 0 clears a flag only when a read of the status word has already returned 1 for it. A set event that arrives between that read and the write cancels the clear. The transmit-end flag is cleared through the transmit-data-empty position of the same word, or by a DMA write to the transmit data register.

Top module: `ser_stat_flags`

## Requirements
- R1: After reset the parity-error flag is 0, transmit-end is 1, the received multiprocessor bit is 0, the transmit multiprocessor bit is 0 and the halt output is 0.
- R2: A frame accepted with a parity error sets the parity-error flag one cycle later, and rx_halt_o is 1 while that flag is 1.
- R3: In the cycle an accepted frame is strobed, rdr_load_o is 1. rdrf_set_o is 1 in that cycle only if the frame has no parity error.
- R4: A frame strobe is ignored while rx_en is 0 or the halt is active. It causes no load, no full strobe, no change to the parity-error flag and no change to the received multiprocessor bit.
- R5: The parity-error flag clears on a status write with bit 3 equal to 0, but only when an earlier status read returned bit 3 as 1 and no write has come since that read. Writing 1 to bit 3, or writing 0 with no such read, has no effect.
- R6: A transmit-end set event that comes after the transmit-data-empty read and before the write cancels that read's arming, so the next write of 0 does not clear transmit-end.
- R7: While tx_en is 0, transmit-end is 1 from the next cycle on. It is also set when tx_last comes while tdre_in is 1. tx_last with tdre_in 0 leaves it unchanged.
- R8: Transmit-end clears one cycle after tdr_dma_wr. It also clears after a status write with bit 7 equal to 0, if an earlier read saw bit 7 (tdre_in) as 1 and no write has come since that read.
- R9: Each accepted frame loads its multiprocessor bit into the received-bit flag. That flag holds its value while rx_en is 0 and ignores status writes.
- R10: Status bit 0 is the transmit multiprocessor bit. A status write loads it, and tx_mpb_o always shows its value.
- R11: If a set event and a qualified clear of the same flag come in the same cycle, the flag ends up 1.
- R12: st_rdata shows transmit multiprocessor bit at bit 0, received multiprocessor bit at bit 1, transmit-end at bit 2, parity-error at bit 3 and tdre_in at bit 7. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receiver enable |
| tx_en | input | 1 | Transmitter enable |
| rx_done | input | 1 | Receive engine frame-complete strobe |
| rx_perr | input | 1 | Parity error on the strobed frame |
| rx_mpb_in | input | 1 | Multiprocessor bit of the strobed frame |
| tx_last | input | 1 | Final bit of a character is being sent |
| tdre_in | input | 1 | Transmit data register empty flag |
| tdr_dma_wr | input | 1 | DMA write to the transmit data register |
| st_rd | input | 1 | Status word read strobe |
| st_wr | input | 1 | Status word write strobe |
| st_wdata | input | DATA_W | Status write data |
| st_rdata | output | DATA_W | Status word read data |
| per_o | output | 1 | Parity-error flag |
| tend_o | output | 1 | Transmit-end flag |
| rx_mpb_o | output | 1 | Captured receive multiprocessor bit |
| tx_mpb_o | output | 1 | Multiprocessor bit appended to transmitted frames |
| rx_halt_o | output | 1 | Receive halt |
| rdr_load_o | output | 1 | Load received byte into the data register |
| rdrf_set_o | output | 1 | Set the receive-data-full flag |

## Verification
On every cycle the assertions check four things: a flag with a set event is 1 in the next cycle, a frame with a parity error that was loaded without a full strobe raises the parity-error flag, a disabled transmitter forces transmit-end, and the transmit and receive multiprocessor bits change only in a write or an accepted frame. They also check that each falling edge of a clearable flag has a write or DMA strobe in the cycle before it. Only the bench scenarios can show the arming rule: a clear with no prior read fails, a write of 1 leaves the flag alone, a set between the read and the write cancels the clear, and reception stays halted until software clears the flag.

// File: rtl/ssf_pkg.sv
package ssf_pkg;

   // Event bundle from the receive shift engine
   typedef struct packed {
      logic done;
      logic perr;
      logic mpb;
   } rx_evt_t;

   // Strobes returned to the receive data path
   typedef struct packed {
      logic load;
      logic full;
      logic per_set;
   } rx_act_t;

endpackage

// File: rtl/ssf_flag_cell.sv
module ssf_flag_cell #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,     // set event
   input  logic rd_i,      // status read strobe
   input  logic seen_i,    // value the read returns at the arming position
   input  logic wr_i,      // status write strobe
   input  logic wbit_i,    // written bit at the arming position
   input  logic alt_clr_i, // unconditional clear source
   output logic q_o
);

   logic q_r;
   logic arm_r;
   logic qual_clr;

   assign qual_clr = wr_i & ~wbit_i & arm_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_r <= RST_VAL;
      end else if (set_i) begin
         q_r <= 1'b1;
      end else if (qual_clr || alt_clr_i) begin
         q_r <= 1'b0;
      end
   end

   // Arming: a read returning 1 arms, a later set event or any write disarms
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_r <= 1'b0;
      end else if (set_i) begin
         arm_r <= 1'b0;
      end else if (rd_i && seen_i) begin
         arm_r <= 1'b1;
      end else if (wr_i) begin
         arm_r <= 1'b0;
      end
   end

   assign q_o = q_r;

   p_set_wins_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o);

endmodule

// File: rtl/ssf_rx_side.sv
module ssf_rx_side
   import ssf_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    rx_en,
   input  logic    halt_i,
   input  rx_evt_t evt_i,
   output rx_act_t act_o,
   output logic    mpb_o
);

   logic accept;
   logic mpb_r;

   assign accept       = evt_i.done & rx_en & ~halt_i;
   assign act_o.load   = accept;
   assign act_o.full   = accept & ~evt_i.perr;
   assign act_o.per_set = accept & evt_i.perr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mpb_r <= 1'b0;
      end else if (accept) begin
         mpb_r <= evt_i.mpb;
      end
   end

   assign mpb_o = mpb_r;

   p_mpb_hold_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      !act_o.load |=> $stable(mpb_o));

endmodule

// File: rtl/ssf_tx_side.sv
module ssf_tx_side (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_en,
   input  logic tx_last,
   input  logic tdre_in,
   input  logic wr_i,
   input  logic mpb_wbit_i,
   output logic tend_set_o,
   output logic mpb_o
);

   logic mpb_r;

   assign tend_set_o = ~tx_en | (tx_last & tdre_in);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mpb_r <= 1'b0;
      end else if (wr_i) begin
         mpb_r <= mpb_wbit_i;
      end
   end

   assign mpb_o = mpb_r;

   p_txmpb_hold_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(mpb_o));

endmodule

// File: rtl/ser_stat_flags.sv
module ser_stat_flags
   import ssf_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int BIT_TXMPB = 0,
   parameter int BIT_RXMPB = 1,
   parameter int BIT_TEND  = 2,
   parameter int BIT_PER   = 3,
   parameter int BIT_TDRE  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_en,
   input  logic              tx_en,
   input  logic              rx_done,
   input  logic              rx_perr,
   input  logic              rx_mpb_in,
   input  logic              tx_last,
   input  logic              tdre_in,
   input  logic              tdr_dma_wr,
   input  logic              st_rd,
   input  logic              st_wr,
   input  logic [DATA_W-1:0] st_wdata,
   output logic [DATA_W-1:0] st_rdata,
   output logic              per_o,
   output logic              tend_o,
   output logic              rx_mpb_o,
   output logic              tx_mpb_o,
   output logic              rx_halt_o,
   output logic              rdr_load_o,
   output logic              rdrf_set_o
);

   localparam int NFIELD = 5;
   localparam int FIELD_POS [NFIELD] = '{BIT_TXMPB, BIT_RXMPB, BIT_TEND, BIT_PER, BIT_TDRE};

   // Elaboration-time parameter checks
   generate
      if (DATA_W < NFIELD) begin : g_chk_width
         $error("DATA_W too small for the status fields");
      end
      for (genvar i = 0; i < NFIELD; i++) begin : g_chk_pos
         if (FIELD_POS[i] < 0 || FIELD_POS[i] >= DATA_W) begin : g_range
            $error("status field position out of range");
         end
         for (genvar j = i + 1; j < NFIELD; j++) begin : g_dup
            if (FIELD_POS[i] == FIELD_POS[j]) begin : g_clash
               $error("two status fields share a bit");
            end
         end
      end
   endgenerate

   rx_evt_t rx_evt;
   rx_act_t rx_act;
   logic    per_q;
   logic    tend_q;
   logic    tend_set;
   logic    rx_mpb_q;
   logic    tx_mpb_q;

   assign rx_evt = '{done: rx_done, perr: rx_perr, mpb: rx_mpb_in};

   ssf_rx_side u_rx (
      .clk    (clk),
      .rst_n  (rst_n),
      .rx_en  (rx_en),
      .halt_i (per_q),
      .evt_i  (rx_evt),
      .act_o  (rx_act),
      .mpb_o  (rx_mpb_q)
   );

   ssf_tx_side u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .tx_en      (tx_en),
      .tx_last    (tx_last),
      .tdre_in    (tdre_in),
      .wr_i       (st_wr),
      .mpb_wbit_i (st_wdata[BIT_TXMPB]),
      .tend_set_o (tend_set),
      .mpb_o      (tx_mpb_q)
   );

   ssf_flag_cell #(.RST_VAL(1'b0)) u_per (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (rx_act.per_set),
      .rd_i      (st_rd),
      .seen_i    (per_q),
      .wr_i      (st_wr),
      .wbit_i    (st_wdata[BIT_PER]),
      .alt_clr_i (1'b0),
      .q_o       (per_q)
   );

   ssf_flag_cell #(.RST_VAL(1'b1)) u_tend (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (tend_set),
      .rd_i      (st_rd),
      .seen_i    (tdre_in),
      .wr_i      (st_wr),
      .wbit_i    (st_wdata[BIT_TDRE]),
      .alt_clr_i (tdr_dma_wr),
      .q_o       (tend_q)
   );

   always_comb begin
      st_rdata            = '0;
      st_rdata[BIT_TXMPB] = tx_mpb_q;
      st_rdata[BIT_RXMPB] = rx_mpb_q;
      st_rdata[BIT_TEND]  = tend_q;
      st_rdata[BIT_PER]   = per_q;
      st_rdata[BIT_TDRE]  = tdre_in;
   end

   assign per_o      = per_q;
   assign tend_o     = tend_q;
   assign rx_mpb_o   = rx_mpb_q;
   assign tx_mpb_o   = tx_mpb_q;
   assign rx_halt_o  = per_q;
   assign rdr_load_o = rx_act.load;
   assign rdrf_set_o = rx_act.full;

   p_per_raise_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (rdr_load_o && !rdrf_set_o) |=> per_o);

   p_per_fall_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(per_o) |-> $past(st_wr && !st_wdata[BIT_PER]));

   p_tend_off_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> tend_o);

   p_tend_fall_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tend_o) |-> $past(tdr_dma_wr || st_wr));

endmodule

// File: tb/tb_ser_stat_flags.sv
module tb_ser_stat_flags;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rx_en = 1'b0, tx_en = 1'b0;
   logic          rx_done = 1'b0, rx_perr = 1'b0, rx_mpb_in = 1'b0;
   logic          tx_last = 1'b0, tdre_in = 1'b0, tdr_dma_wr = 1'b0;
   logic          st_rd = 1'b0, st_wr = 1'b0;
   logic [DW-1:0] st_wdata = '0;
   logic [DW-1:0] st_rdata;
   logic          per_o, tend_o, rx_mpb_o, tx_mpb_o, rx_halt_o, rdr_load_o, rdrf_set_o;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ser_stat_flags dut (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tx_en(tx_en),
      .rx_done(rx_done), .rx_perr(rx_perr), .rx_mpb_in(rx_mpb_in),
      .tx_last(tx_last), .tdre_in(tdre_in), .tdr_dma_wr(tdr_dma_wr),
      .st_rd(st_rd), .st_wr(st_wr), .st_wdata(st_wdata), .st_rdata(st_rdata),
      .per_o(per_o), .tend_o(tend_o), .rx_mpb_o(rx_mpb_o), .tx_mpb_o(tx_mpb_o),
      .rx_halt_o(rx_halt_o), .rdr_load_o(rdr_load_o), .rdrf_set_o(rdrf_set_o)
   );

   task automatic chk(input string req, input string what, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Drive strobes just after a falling edge; they are captured at the next rising edge
   task automatic step();
      @(negedge clk);
   endtask

   task automatic clear_strobes();
      rx_done = 0; rx_perr = 0; rx_mpb_in = 0; tx_last = 0;
      tdr_dma_wr = 0; st_rd = 0; st_wr = 0; st_wdata = '0;
   endtask

   task automatic t_reset();
      chk("R1", "per", per_o, 0);
      chk("R1", "tend", tend_o, 1);
      chk("R1", "rx_mpb", rx_mpb_o, 0);
      chk("R1", "tx_mpb", tx_mpb_o, 0);
      chk("R1", "halt", rx_halt_o, 0);
      chk("R12", "rdata reset", st_rdata, 8'h04);
   endtask

   task automatic t_rx_frames();
      rx_en = 1;
      rx_done = 1; rx_perr = 0; rx_mpb_in = 1;
      #1;
      chk("R3", "load good", rdr_load_o, 1);
      chk("R3", "full good", rdrf_set_o, 1);
      step(); clear_strobes(); #1;
      chk("R9", "mpb captured", rx_mpb_o, 1);
      chk("R3", "per after good", per_o, 0);
      rx_done = 1; rx_perr = 1; rx_mpb_in = 0;
      #1;
      chk("R3", "load perr", rdr_load_o, 1);
      chk("R3", "full perr", rdrf_set_o, 0);
      step(); clear_strobes(); #1;
      chk("R2", "per set", per_o, 1);
      chk("R2", "halt", rx_halt_o, 1);
      chk("R9", "mpb perr frame", rx_mpb_o, 0);
      rx_done = 1; rx_perr = 0; rx_mpb_in = 1;
      #1;
      chk("R4", "load halted", rdr_load_o, 0);
      chk("R4", "full halted", rdrf_set_o, 0);
      step(); clear_strobes(); #1;
      chk("R4", "mpb halted", rx_mpb_o, 0);
      chk("R4", "per halted", per_o, 1);
   endtask

   task automatic t_per_clear();
      st_wr = 1; st_wdata = 8'h00;
      step(); clear_strobes(); #1;
      chk("R5", "no read no clear", per_o, 1);
      st_rd = 1; #1;
      chk("R12", "per bit read", st_rdata[3], 1);
      step(); clear_strobes();
      st_wr = 1; st_wdata = 8'hFF;
      step(); clear_strobes(); #1;
      chk("R5", "write one no clear", per_o, 1);
      chk("R10", "tx_mpb written 1", tx_mpb_o, 1);
      st_rd = 1;
      step(); clear_strobes();
      st_wr = 1; st_wdata = 8'h00;
      step(); clear_strobes(); #1;
      chk("R5", "qualified clear", per_o, 0);
      chk("R2", "halt released", rx_halt_o, 0);
      chk("R10", "tx_mpb written 0", tx_mpb_o, 0);
   endtask

   task automatic t_rx_disabled();
      rx_done = 1; rx_mpb_in = 1;
      step(); clear_strobes(); #1;
      chk("R9", "mpb before disable", rx_mpb_o, 1);
      rx_en = 0;
      repeat (3) step();
      rx_done = 1; rx_perr = 1; rx_mpb_in = 0;
      #1;
      chk("R4", "load disabled", rdr_load_o, 0);
      step(); clear_strobes(); #1;
      chk("R4", "per disabled", per_o, 0);
      chk("R9", "mpb retained", rx_mpb_o, 1);
   endtask

   task automatic t_tend();
      tx_en = 1;
      step(); #1;
      st_wr = 1; st_wdata = 8'h00;
      step(); clear_strobes(); #1;
      chk("R8", "no read no clear", tend_o, 1);
      chk("R9", "rx_mpb read-only", rx_mpb_o, 1);
      tdre_in = 1; st_rd = 1; #1;
      chk("R12", "rdata layout", st_rdata, 8'h86);
      step(); clear_strobes();
      st_wr = 1; st_wdata = 8'h00;
      step(); clear_strobes(); #1;
      chk("R8", "qualified tdre clear", tend_o, 0);
      tdre_in = 0; tx_last = 1;
      step(); clear_strobes(); #1;
      chk("R7", "last bit tdre 0", tend_o, 0);
      tdre_in = 1; tx_last = 1;
      step(); clear_strobes(); #1;
      chk("R7", "last bit tdre 1", tend_o, 1);
      tdr_dma_wr = 1;
      step(); clear_strobes(); #1;
      chk("R8", "dma clear", tend_o, 0);
   endtask

   task automatic t_disarm_and_wins();
      st_rd = 1;
      step(); clear_strobes();
      tx_last = 1;
      step(); clear_strobes(); #1;
      chk("R7", "set after read", tend_o, 1);
      st_wr = 1; st_wdata = 8'h00;
      step(); clear_strobes(); #1;
      chk("R6", "disarmed write", tend_o, 1);
      st_rd = 1;
      step(); clear_strobes();
      st_wr = 1; st_wdata = 8'h00; tx_last = 1;
      step(); clear_strobes(); #1;
      chk("R11", "set wins", tend_o, 1);
      tdr_dma_wr = 1;
      step(); clear_strobes();
      tx_en = 0; tdr_dma_wr = 1;
      step(); clear_strobes(); #1;
      chk("R11", "tx off beats dma", tend_o, 1);
      step(); #1;
      chk("R7", "tx off forced", tend_o, 1);
   endtask

   task automatic t_tx_mpb();
      st_wr = 1; st_wdata = 8'h01;
      step(); clear_strobes(); #1;
      chk("R10", "tx_mpb set", tx_mpb_o, 1);
      st_rd = 1;
      step(); clear_strobes(); #1;
      chk("R10", "read keeps tx_mpb", tx_mpb_o, 1);
      st_wr = 1; st_wdata = 8'h00;
      step(); clear_strobes(); #1;
      chk("R10", "tx_mpb clear", tx_mpb_o, 0);
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      repeat (3) step();
      rst_n = 1;
      step(); #1;
      t_reset();
      t_rx_frames();
      t_per_clear();
      t_rx_disabled();
      t_tend();
      t_disarm_and_wins();
      t_tx_mpb();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule